// File: doc/BRIEF.md
# Frame Buffer Registration Table with Palette Base Loader

This block holds a table of frame buffer descriptors that software fills through a small register window. Each descriptor is keyed by an 8-bit identifier. It holds a line pitch and a base address kept in a 256-byte granule. A descriptor is written as three register writes, and it enters the table only when all three arrive in the required order: identifier, then pitch, then base. Any other order discards the partial descriptor. A display pipeline elsewhere in the chip reads descriptors back through a lookup port. One cycle after a request, the port returns the pitch and the full byte address, rebuilt from the stored granule.

A second register group in the same window holds the base of a colour palette in 16-byte granules. It also has an apply word. Writing the value one to the apply word sends a single-cycle pulse, together with the palette byte address, to a palette loader. A third word in this group is stored but has no effect. While the display output is marked inactive, every register write is dropped.

Top module: `fbreg_table`

## Requirements
- R1: After reset, no identifier is registered, the lookup outputs are low, and `pal_apply` and `pal_addr` are zero.
- R2: A write to byte offset 0x00 (identifier, `wr_data[7:0]`), then offset 0x04 (pitch, `wr_data[15:0]`), then offset 0x08 (base granule, `wr_data[23:0]`) registers that identifier with that pitch and granule. Writes to other offsets may come between these three.
- R3: When `lk_en` is sampled high, `lk_valid` goes high in the next cycle. If the identifier is registered, `lk_hit` is 1, `lk_pitch` is the stored pitch, and `lk_addr` is the granule shifted left by 8.
- R4: A pitch write that does not follow an identifier write returns the tracker to idle. So does a base write that does not follow a pitch write. Neither one registers anything. An identifier write always starts a new sequence with the new identifier.
- R5: While `out_active` is low, register writes have no effect on the table, on the sequence tracker or on the palette group.
- R6: Offset 0x18 stores the palette granule (`wr_data[27:0]`). A write of exactly 0x1 to offset 0x10 raises `pal_apply` for one cycle, in the cycle after the write, with `pal_addr` equal to the granule shifted left by 4. Any other value written to 0x10 raises no pulse. `pal_addr` changes only when a pulse is raised.
- R7: Writes to offset 0x14 and to the other palette offsets change neither the palette outputs nor the progress of a buffer sequence.
- R8: Registering an identifier again replaces its previous pitch and granule.
- R9: A lookup of an identifier that is not registered returns `lk_hit` 0, with `lk_pitch` and `lk_addr` both zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| out_active | input | 1 | Display output active; writes are accepted only while high |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 5 | Register byte offset |
| wr_data | input | 32 | Register write data |
| lk_en | input | 1 | Lookup request |
| lk_id | input | 8 | Identifier to look up |
| lk_valid | output | 1 | Lookup result valid (one cycle after request) |
| lk_hit | output | 1 | Identifier is registered |
| lk_pitch | output | 16 | Registered pitch |
| lk_addr | output | 32 | Registered buffer byte address |
| pal_apply | output | 1 | One-cycle palette apply pulse |
| pal_addr | output | 32 | Palette byte address |

## Verification
The bench fills all 256 identifiers with pitches and granules computed arithmetically. The upper data bits it writes are filled with junk, so a design that took the wrong field slice, or forgot the shift by 8, returns addresses that do not match. Broken sequences are tested as well: a base without a pitch, a repeated pitch, and an identifier restarted in the middle of a sequence. A tracker that does not reset on these cases would register stale or mixed descriptors. Writes made while the output is inactive, placed between a pitch and its base, show whether a dropped write still advanced or cleared the tracker. Palette tests apply non-one values, the ignored word, and inactive granule updates, to catch a pulse that should not happen or an address that moves without one.

// File: rtl/fbreg_pkg.sv
package fbreg_pkg;

    localparam int REG_AW = 5;

    localparam logic [REG_AW-1:0] OFS_ID    = 5'h00;
    localparam logic [REG_AW-1:0] OFS_PITCH = 5'h04;
    localparam logic [REG_AW-1:0] OFS_BASE  = 5'h08;
    localparam logic [REG_AW-1:0] OFS_APPLY = 5'h10;
    localparam logic [REG_AW-1:0] OFS_FLAG  = 5'h14;
    localparam logic [REG_AW-1:0] OFS_PPTR  = 5'h18;

    typedef enum logic [2:0] {
        SEL_NONE,
        SEL_ID,
        SEL_PITCH,
        SEL_BASE,
        SEL_APPLY,
        SEL_FLAG,
        SEL_PPTR
    } wsel_e;

    typedef enum logic [1:0] {
        SQ_IDLE,
        SQ_HAVE_ID,
        SQ_HAVE_PITCH
    } seq_e;

    function automatic wsel_e decode_ofs(input logic [REG_AW-1:0] ofs);
        case (ofs)
            OFS_ID:    return SEL_ID;
            OFS_PITCH: return SEL_PITCH;
            OFS_BASE:  return SEL_BASE;
            OFS_APPLY: return SEL_APPLY;
            OFS_FLAG:  return SEL_FLAG;
            OFS_PPTR:  return SEL_PPTR;
            default:   return SEL_NONE;
        endcase
    endfunction

endpackage

// File: rtl/fbreg_seq.sv
module fbreg_seq
    import fbreg_pkg::*;
#(
    parameter int ID_W    = 8,
    parameter int PITCH_W = 16,
    parameter int BASE_W  = 24,
    parameter int DATA_W  = 24
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               wr_ok,
    input  wsel_e              sel,
    input  logic [DATA_W-1:0]  data,
    output logic               commit,
    output logic [ID_W-1:0]    commit_id,
    output logic [PITCH_W-1:0] commit_pitch,
    output logic [BASE_W-1:0]  commit_base
);

    typedef struct packed {
        seq_e               st;
        logic [ID_W-1:0]    id;
        logic [PITCH_W-1:0] pitch;
    } seq_t;

    seq_t s_d, s_q;
    logic commit_d;

    always_comb begin
        s_d      = s_q;
        commit_d = 1'b0;
        if (wr_ok) begin
            case (sel)
                SEL_ID: begin
                    s_d.st = SQ_HAVE_ID;
                    s_d.id = data[ID_W-1:0];
                end
                SEL_PITCH: begin
                    if (s_q.st == SQ_HAVE_ID) begin
                        s_d.st    = SQ_HAVE_PITCH;
                        s_d.pitch = data[PITCH_W-1:0];
                    end else begin
                        s_d.st = SQ_IDLE;
                    end
                end
                SEL_BASE: begin
                    commit_d = (s_q.st == SQ_HAVE_PITCH);
                    s_d.st   = SQ_IDLE;
                end
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q <= '{st: SQ_IDLE, id: '0, pitch: '0};
        end else begin
            s_q <= s_d;
        end
    end

    assign commit       = commit_d;
    assign commit_id    = s_q.id;
    assign commit_pitch = s_q.pitch;
    assign commit_base  = data[BASE_W-1:0];

endmodule

// File: rtl/fbreg_store.sv
module fbreg_store #(
    parameter int ID_W      = 8,
    parameter int PITCH_W   = 16,
    parameter int BUF_SHIFT = 8,
    parameter int ADDR_W    = 32
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          wr_en,
    input  logic [ID_W-1:0]               wr_id,
    input  logic [PITCH_W-1:0]            wr_pitch,
    input  logic [ADDR_W-BUF_SHIFT-1:0]   wr_base,
    input  logic                          lk_en,
    input  logic [ID_W-1:0]               lk_id,
    output logic                          lk_valid,
    output logic                          lk_hit,
    output logic [PITCH_W-1:0]            lk_pitch,
    output logic [ADDR_W-1:0]             lk_addr
);

    localparam int DEPTH  = 1 << ID_W;
    localparam int BASE_W = ADDR_W - BUF_SHIFT;

    typedef struct packed {
        logic               valid;
        logic               hit;
        logic [PITCH_W-1:0] pitch;
        logic [ADDR_W-1:0]  addr;
    } look_t;

    logic [DEPTH-1:0]   used_q;
    logic [PITCH_W-1:0] pitch_mem_q [DEPTH];
    logic [BASE_W-1:0]  base_mem_q  [DEPTH];

    look_t r_d, r_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            used_q <= '0;
        end else if (wr_en) begin
            used_q[wr_id] <= 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (wr_en) begin
            pitch_mem_q[wr_id] <= wr_pitch;
            base_mem_q[wr_id]  <= wr_base;
        end
    end

    always_comb begin
        r_d       = r_q;
        r_d.valid = lk_en;
        if (lk_en) begin
            r_d.hit   = used_q[lk_id];
            r_d.pitch = '0;
            r_d.addr  = '0;
            if (used_q[lk_id]) begin
                r_d.pitch = pitch_mem_q[lk_id];
                r_d.addr  = {base_mem_q[lk_id], {BUF_SHIFT{1'b0}}};
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q <= '0;
        end else begin
            r_q <= r_d;
        end
    end

    assign lk_valid = r_q.valid;
    assign lk_hit   = r_q.hit;
    assign lk_pitch = r_q.pitch;
    assign lk_addr  = r_q.addr;

endmodule

// File: rtl/fbreg_pal.sv
module fbreg_pal
    import fbreg_pkg::*;
#(
    parameter int PAL_SHIFT = 4,
    parameter int ADDR_W    = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_ok,
    input  wsel_e             sel,
    input  logic [31:0]       data,
    output logic              pal_apply,
    output logic [ADDR_W-1:0] pal_addr
);

    localparam int PPTR_W = ADDR_W - PAL_SHIFT;

    typedef struct packed {
        logic [PPTR_W-1:0] pptr;
        logic [31:0]       flag;
        logic              apply;
        logic [ADDR_W-1:0] addr;
    } pal_t;

    pal_t p_d, p_q;

    always_comb begin
        p_d       = p_q;
        p_d.apply = 1'b0;
        if (wr_ok) begin
            case (sel)
                SEL_PPTR: p_d.pptr = data[PPTR_W-1:0];
                SEL_FLAG: p_d.flag = data;
                SEL_APPLY: begin
                    if (data == 32'h1) begin
                        p_d.apply = 1'b1;
                        p_d.addr  = {p_q.pptr, {PAL_SHIFT{1'b0}}};
                    end
                end
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            p_q <= '0;
        end else begin
            p_q <= p_d;
        end
    end

    assign pal_apply = p_q.apply;
    assign pal_addr  = p_q.addr;

endmodule

// File: rtl/fbreg_table.sv
module fbreg_table
    import fbreg_pkg::*;
#(
    parameter int ID_W      = 8,
    parameter int PITCH_W   = 16,
    parameter int ADDR_W    = 32,
    parameter int BUF_SHIFT = 8,
    parameter int PAL_SHIFT = 4
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               out_active,
    input  logic               wr_en,
    input  logic [REG_AW-1:0]  wr_addr,
    input  logic [31:0]        wr_data,
    input  logic               lk_en,
    input  logic [ID_W-1:0]    lk_id,
    output logic               lk_valid,
    output logic               lk_hit,
    output logic [PITCH_W-1:0] lk_pitch,
    output logic [ADDR_W-1:0]  lk_addr,
    output logic               pal_apply,
    output logic [ADDR_W-1:0]  pal_addr
);

    localparam int BASE_W = ADDR_W - BUF_SHIFT;
    localparam int MAX_IP = (ID_W > PITCH_W) ? ID_W : PITCH_W;
    localparam int SEQ_DW = (MAX_IP > BASE_W) ? MAX_IP : BASE_W;

    wsel_e              sel;
    logic               wr_ok;
    logic               commit;
    logic [ID_W-1:0]    commit_id;
    logic [PITCH_W-1:0] commit_pitch;
    logic [BASE_W-1:0]  commit_base;

    assign sel   = decode_ofs(wr_addr);
    assign wr_ok = wr_en && out_active;

    fbreg_seq #(
        .ID_W    (ID_W),
        .PITCH_W (PITCH_W),
        .BASE_W  (BASE_W),
        .DATA_W  (SEQ_DW)
    ) u_seq (
        .clk          (clk),
        .rst_n        (rst_n),
        .wr_ok        (wr_ok),
        .sel          (sel),
        .data         (wr_data[SEQ_DW-1:0]),
        .commit       (commit),
        .commit_id    (commit_id),
        .commit_pitch (commit_pitch),
        .commit_base  (commit_base)
    );

    fbreg_store #(
        .ID_W      (ID_W),
        .PITCH_W   (PITCH_W),
        .BUF_SHIFT (BUF_SHIFT),
        .ADDR_W    (ADDR_W)
    ) u_store (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (commit),
        .wr_id    (commit_id),
        .wr_pitch (commit_pitch),
        .wr_base  (commit_base),
        .lk_en    (lk_en),
        .lk_id    (lk_id),
        .lk_valid (lk_valid),
        .lk_hit   (lk_hit),
        .lk_pitch (lk_pitch),
        .lk_addr  (lk_addr)
    );

    fbreg_pal #(
        .PAL_SHIFT (PAL_SHIFT),
        .ADDR_W    (ADDR_W)
    ) u_pal (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_ok     (wr_ok),
        .sel       (sel),
        .data      (wr_data),
        .pal_apply (pal_apply),
        .pal_addr  (pal_addr)
    );

endmodule

// File: rtl/fbreg_table_chk.sv
module fbreg_table_chk
    import fbreg_pkg::*;
#(
    parameter int PITCH_W   = 16,
    parameter int ADDR_W    = 32,
    parameter int BUF_SHIFT = 8
) (
    input logic               clk,
    input logic               rst_n,
    input logic               out_active,
    input logic               wr_en,
    input logic [REG_AW-1:0]  wr_addr,
    input logic [31:0]        wr_data,
    input logic               lk_en,
    input logic               lk_valid,
    input logic               lk_hit,
    input logic [PITCH_W-1:0] lk_pitch,
    input logic [ADDR_W-1:0]  lk_addr,
    input logic               pal_apply,
    input logic [ADDR_W-1:0]  pal_addr
);

    // R3: result valid exactly one cycle after the request
    p_latency_r3: assert property (@(posedge clk) disable iff (!rst_n)
        lk_valid == $past(lk_en));

    // R3: a hit always returns a granule-aligned byte address
    p_align_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (lk_valid && lk_hit) |-> (lk_addr[BUF_SHIFT-1:0] == '0));

    // R9: a miss returns zero pitch and address
    p_miss_zero_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (lk_valid && !lk_hit) |-> (lk_pitch == '0 && lk_addr == '0));

    // R6: a pulse only follows an accepted write of one to the apply word
    p_apply_src_r6: assert property (@(posedge clk) disable iff (!rst_n)
        pal_apply |-> $past(wr_en && out_active && wr_addr == OFS_APPLY && wr_data == 32'h1));

    // R6: palette address moves only with a pulse
    p_addr_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !pal_apply |-> $stable(pal_addr));

    // R5: a write while inactive never raises a pulse
    p_inactive_drop_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && !out_active) |=> !pal_apply);

endmodule

bind fbreg_table fbreg_table_chk #(
    .PITCH_W   (PITCH_W),
    .ADDR_W    (ADDR_W),
    .BUF_SHIFT (BUF_SHIFT)
) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .out_active (out_active),
    .wr_en      (wr_en),
    .wr_addr    (wr_addr),
    .wr_data    (wr_data),
    .lk_en      (lk_en),
    .lk_valid   (lk_valid),
    .lk_hit     (lk_hit),
    .lk_pitch   (lk_pitch),
    .lk_addr    (lk_addr),
    .pal_apply  (pal_apply),
    .pal_addr   (pal_addr)
);

// File: tb/sim_fbreg_table.sv
module sim_fbreg_table;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        out_active = 1'b1;
    logic        wr_en = 1'b0;
    logic [4:0]  wr_addr = '0;
    logic [31:0] wr_data = '0;
    logic        lk_en = 1'b0;
    logic [7:0]  lk_id = '0;
    logic        lk_valid;
    logic        lk_hit;
    logic [15:0] lk_pitch;
    logic [31:0] lk_addr;
    logic        pal_apply;
    logic [31:0] pal_addr;

    always #5 clk = ~clk;

    fbreg_table u0 (
        .clk(clk), .rst_n(rst_n), .out_active(out_active),
        .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .lk_en(lk_en), .lk_id(lk_id),
        .lk_valid(lk_valid), .lk_hit(lk_hit), .lk_pitch(lk_pitch), .lk_addr(lk_addr),
        .pal_apply(pal_apply), .pal_addr(pal_addr)
    );

    int total = 0;
    int bad   = 0;
    bit done  = 1'b0;

    bit          m_used  [256];
    logic [15:0] m_pitch [256];
    logic [23:0] m_base  [256];

    function automatic logic [15:0] f_pitch(input int i);
        return 16'((i * 37 + 5) & 32'hFFFF);
    endfunction

    function automatic logic [23:0] f_base(input int i);
        return 24'((i * 32'h0001_0203 + 32'h00A5) & 32'hFF_FFFF);
    endfunction

    task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s act=%h exp=%h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [4:0] a, input logic [31:0] d, input bit act = 1'b1);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = a; wr_data = d; out_active = act;
        @(negedge clk);
        wr_en = 1'b0; out_active = 1'b1;
    endtask

    task automatic entry(input string tag, input int id);
        @(negedge clk);
        lk_en = 1'b1; lk_id = 8'(id);
        @(negedge clk);
        lk_en = 1'b0;
        check({tag, " valid"}, 64'(lk_valid), 64'd1);
        check({tag, " hit"}, 64'(lk_hit), 64'(m_used[id]));
        check({tag, " pitch"}, 64'(lk_pitch), m_used[id] ? 64'(m_pitch[id]) : 64'd0);
        check({tag, " addr"}, 64'(lk_addr), m_used[id] ? 64'({m_base[id], 8'h00}) : 64'd0);
    endtask

    task automatic reg3(input int id, input logic [15:0] p, input logic [23:0] b);
        wr(5'h00, {24'h5A5A5A, 8'(id)});
        wr(5'h04, {16'hDEAD, p});
        wr(5'h08, {8'hEE, b});
        m_used[id] = 1'b1; m_pitch[id] = p; m_base[id] = b;
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        total++; bad++;
        $display("FAIL watchdog expired act=running exp=finished");
        finish_run();
    end

    initial begin
        for (int i = 0; i < 256; i++) begin
            m_used[i] = 1'b0; m_pitch[i] = '0; m_base[i] = '0;
        end
        repeat (3) @(negedge clk);
        // R1: outputs after reset
        check("R1 lk_valid", 64'(lk_valid), 64'd0);
        check("R1 pal_apply", 64'(pal_apply), 64'd0);
        check("R1 pal_addr", 64'(pal_addr), 64'd0);
        rst_n = 1'b1;
        @(negedge clk);
        entry("R1 empty id0", 0);
        entry("R1 empty id255", 255);
        check("R3 valid drops", 64'(lk_valid), 64'd1);
        @(negedge clk);
        check("R3 valid one cycle", 64'(lk_valid), 64'd0);

        // R4: base without pitch
        wr(5'h00, 32'h11);
        wr(5'h08, 32'h123456);
        entry("R4 base skip", 8'h11);
        // R4: tracker idle after failure, pitch+base do nothing
        wr(5'h04, 32'h40);
        wr(5'h08, 32'h123456);
        entry("R4 idle after fail", 8'h11);
        // R4: repeated pitch resets
        wr(5'h00, 32'h12);
        wr(5'h04, 32'h40);
        wr(5'h04, 32'h44);
        wr(5'h08, 32'h654321);
        entry("R4 double pitch", 8'h12);
        // R4: ID restart mid-sequence
        wr(5'h00, 32'h13);
        wr(5'h04, 32'h50);
        wr(5'h00, 32'h14);
        wr(5'h04, 32'h60);
        wr(5'h08, 32'h0ABCDE);
        m_used[8'h14] = 1'b1; m_pitch[8'h14] = 16'h60; m_base[8'h14] = 24'h0ABCDE;
        entry("R4 restart old", 8'h13);
        entry("R4 restart new", 8'h14);

        // R5: inactive base write is dropped, tracker keeps its place
        wr(5'h00, 32'h21);
        wr(5'h04, 32'h70);
        wr(5'h08, 32'h111111, 1'b0);
        entry("R5 inactive base", 8'h21);
        wr(5'h08, 32'h222222);
        m_used[8'h21] = 1'b1; m_pitch[8'h21] = 16'h70; m_base[8'h21] = 24'h222222;
        entry("R5 tracker kept", 8'h21);
        // R5: inactive ID write does not restart
        wr(5'h00, 32'h22);
        wr(5'h00, 32'h23, 1'b0);
        wr(5'h04, 32'h71);
        wr(5'h08, 32'h333333);
        m_used[8'h22] = 1'b1; m_pitch[8'h22] = 16'h71; m_base[8'h22] = 24'h333333;
        entry("R5 inactive id kept", 8'h22);
        entry("R5 inactive id dropped", 8'h23);

        // R7: palette writes between pitch and base
        wr(5'h00, 32'h31);
        wr(5'h04, 32'h80);
        wr(5'h14, 32'hFF);
        wr(5'h18, 32'h0000_0010);
        wr(5'h08, 32'h444444);
        m_used[8'h31] = 1'b1; m_pitch[8'h31] = 16'h80; m_base[8'h31] = 24'h444444;
        entry("R7 seq through palette", 8'h31);

        // R6: palette granule and apply
        wr(5'h18, 32'h0123_4567);
        check("R6 no pulse on pptr", 64'(pal_apply), 64'd0);
        wr(5'h10, 32'h1);
        check("R6 pulse", 64'(pal_apply), 64'd1);
        check("R6 addr", 64'(pal_addr), 64'h1234_5670);
        @(negedge clk);
        check("R6 pulse one cycle", 64'(pal_apply), 64'd0);
        wr(5'h18, 32'h0FFF_FFFF);
        wr(5'h10, 32'h3);
        check("R6 non-one no pulse", 64'(pal_apply), 64'd0);
        check("R6 addr held", 64'(pal_addr), 64'h1234_5670);
        // R7: flag word no effect
        wr(5'h14, 32'hFF);
        check("R7 flag no pulse", 64'(pal_apply), 64'd0);
        check("R7 flag addr held", 64'(pal_addr), 64'h1234_5670);
        // R5: inactive pptr and apply
        wr(5'h18, 32'h0000_0001, 1'b0);
        wr(5'h10, 32'h1, 1'b0);
        check("R5 inactive apply", 64'(pal_apply), 64'd0);
        wr(5'h10, 32'h1);
        check("R6 second pulse", 64'(pal_apply), 64'd1);
        check("R5 inactive pptr dropped", 64'(pal_addr), 64'hFFFF_FFF0);

        // R2, R3: exhaustive registration and lookup
        for (int i = 0; i < 256; i++) reg3(i, f_pitch(i), f_base(i));
        for (int i = 0; i < 256; i++) entry("R2 R3 sweep", i);

        // R8: overwrite
        reg3(8'h80, 16'hBEEF, 24'hC0FFEE);
        entry("R8 overwrite", 8'h80);
        entry("R8 neighbour", 8'h7F);

        finish_run();
    end

endmodule